// File: doc/BRIEF.md
# Multifunction Register with Shared Carry Cells

This block is a W-bit register whose next value comes from a row of identical bit cells. Each cell holds one adder-style slice: a sum path made of XOR gates and a carry that ripples to the next cell. Three command inputs choose the transfer for the cycle. It can shift the register left, replace it with its bitwise XOR against an operand bus, or replace it with the sum of itself and the operand. When no command is active, the register keeps its value.

One control decoder drives every cell with the same signals. The add and shift transfers use the same carry chain. A left shift is computed as the register added to itself, so the carry out of cell i-1 is exactly bit i-1 of the register, and that carry becomes bit i. For the XOR transfer the carry is forced to zero, which leaves each cell output as the XOR of its two inputs. A carry flag is registered along with the value. It holds the final adder carry, the bit shifted out of the top, or zero after an XOR.

Top module: `mfreg_top`

## Requirements
- R1: A synchronous active-high reset clears the register and the carry flag to 0 at the next rising clock edge, and it overrides any command given in the same cycle.
- R2: When none of the three commands is high at a rising edge, the register and the carry flag keep their values, whatever the operand bus holds.
- R3: With the add command high, at the next edge the register becomes (register + operand) modulo 2^W with a carry-in of 0, and the carry flag becomes the carry out of bit W-1.
- R4: With the XOR command high and the add command low, at the next edge the register becomes register XOR operand, and the carry flag becomes 0.
- R5: With only the shift command high, at the next edge bits W-1..1 of the register take the old bits W-2..0, bit 0 becomes 0, and the carry flag takes the old bit W-1.
- R6: When more than one command is high, add wins over XOR and XOR wins over shift. The winning command is carried out exactly as if it were the only one asserted.
- R7: During a shift the operand bus has no effect on the register or on the carry flag.
- R8: The register loads whenever at least one command is high, and it loads exactly one clock edge after the command is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_shl | input | 1 | Command: shift left by one |
| cmd_xor | input | 1 | Command: load register XOR operand |
| cmd_add | input | 1 | Command: load register plus operand |
| b_in | input | W | Operand bus |
| a_out | output | W | Register contents |
| carry_out | output | 1 | Registered carry flag |

## Verification
Several add vectors wrap exactly through 2^W. A design that dropped or misrouted the last carry would show a wrong carry flag, or it would leave a non-zero residue in the register. Shifts run with the top bit set and with a busy operand bus. A design that left the carry kill or the operand select wrong would leak operand bits into the shifted value. Vectors with two and with three commands high expose a priority order that is wrong. Idle cycles and a reset that arrives together with a command expose a load enable that fires when it should not, or a reset that loses to a load. A long random command run, idle cycles included, is compared against a reference model written in integer arithmetic.

// File: rtl/mfreg_pkg.sv
package mfreg_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_XORB  = 2'd2,
    OP_SUM   = 2'd3
  } op_e;

  // sum output of one slice
  function automatic logic slice_sum(input logic a, input logic x, input logic c);
    return a ^ x ^ c;
  endfunction

  // carry output of one slice; kill forces the chain to zero
  function automatic logic slice_carry(input logic a, input logic x,
                                       input logic c, input logic kill);
    return ~kill & ((a & x) | (c & (a ^ x)));
  endfunction

endpackage

// File: rtl/mfreg_ctrl.sv
module mfreg_ctrl
  import mfreg_pkg::*;
(
  input  logic cmd_shl,
  input  logic cmd_xor,
  input  logic cmd_add,
  output op_e  op,
  output logic sel_shl,
  output logic sel_xor,
  output logic sel_add,
  output logic load_en,
  output logic carry_kill,
  output logic pick_a
);

  // priority: sum over xor over shift
  always_comb begin
    if (cmd_add)      op = OP_SUM;
    else if (cmd_xor) op = OP_XORB;
    else if (cmd_shl) op = OP_SHIFT;
    else              op = OP_IDLE;
  end

  assign sel_add    = (op == OP_SUM);
  assign sel_xor    = (op == OP_XORB);
  assign sel_shl    = (op == OP_SHIFT);
  assign load_en    = cmd_shl | cmd_xor | cmd_add;
  assign carry_kill = sel_xor;
  assign pick_a     = sel_shl;

endmodule

// File: rtl/mfreg_cell.sv
module mfreg_cell
  import mfreg_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  input  logic pick_a,
  input  logic carry_kill,
  output logic nxt_bit,
  output logic c_out
);

  logic operand;

  // shifting is A + A, so the second operand is the bit itself
  assign operand = pick_a ? a_bit : b_bit;
  assign nxt_bit = slice_sum(a_bit, operand, c_in);
  assign c_out   = slice_carry(a_bit, operand, c_in, carry_kill);

endmodule

// File: rtl/mfreg_chain.sv
module mfreg_chain #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_vec,
  input  logic [W-1:0] b_vec,
  input  logic         pick_a,
  input  logic         carry_kill,
  output logic [W-1:0] nxt_vec,
  output logic         carry_top
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    mfreg_cell u_cell (
      .a_bit      (a_vec[i]),
      .b_bit      (b_vec[i]),
      .c_in       (carry[i]),
      .pick_a     (pick_a),
      .carry_kill (carry_kill),
      .nxt_bit    (nxt_vec[i]),
      .c_out      (carry[i+1])
    );
  end

  assign carry_top = carry[W];

endmodule

// File: rtl/mfreg_top.sv
module mfreg_top
  import mfreg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_shl,
  input  logic         cmd_xor,
  input  logic         cmd_add,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         carry_out
);

  op_e         op;
  logic        sel_shl, sel_xor, sel_add;
  logic        load_en, carry_kill, pick_a;
  logic [W-1:0] a_q, a_nxt;
  logic        c_q, c_nxt;

  mfreg_ctrl u_ctrl (
    .cmd_shl    (cmd_shl),
    .cmd_xor    (cmd_xor),
    .cmd_add    (cmd_add),
    .op         (op),
    .sel_shl    (sel_shl),
    .sel_xor    (sel_xor),
    .sel_add    (sel_add),
    .load_en    (load_en),
    .carry_kill (carry_kill),
    .pick_a     (pick_a)
  );

  mfreg_chain #(.W(W)) u_chain (
    .a_vec      (a_q),
    .b_vec      (b_in),
    .pick_a     (pick_a),
    .carry_kill (carry_kill),
    .nxt_vec    (a_nxt),
    .carry_top  (c_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      c_q <= 1'b0;
    end else if (load_en) begin
      a_q <= a_nxt;
      c_q <= c_nxt;
    end
  end

  assign a_out     = a_q;
  assign carry_out = c_q;

endmodule

// File: rtl/mfreg_chk.sv
module mfreg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_shl,
  input logic         cmd_xor,
  input logic         cmd_add,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         carry_out,
  input logic         sel_shl,
  input logic         sel_xor,
  input logic         sel_add,
  input logic         load_en
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (a_out == '0) && !carry_out); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(cmd_shl || cmd_xor || cmd_add) |=> $stable(a_out) && $stable(carry_out)); // R2

  AST_SUM_RESULT: assert property (@(posedge clk) disable iff (rst)
    cmd_add |=> {carry_out, a_out} == ({1'b0, $past(a_out)} + {1'b0, $past(b_in)})); // R3

  AST_XOR_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (cmd_xor && !cmd_add) |=> !carry_out); // R4

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (rst)
    (cmd_shl && !cmd_xor && !cmd_add) |=> !a_out[0] && (carry_out == $past(a_out[W-1]))); // R5

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_shl, sel_xor, sel_add}) && (load_en == (sel_shl || sel_xor || sel_add))); // R6

  AST_SUM_WINS: assert property (@(posedge clk) disable iff (rst)
    cmd_add |-> sel_add); // R6

  AST_LOAD_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (cmd_shl || cmd_xor || cmd_add)); // R8

endmodule

bind mfreg_top mfreg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_shl   (cmd_shl),
  .cmd_xor   (cmd_xor),
  .cmd_add   (cmd_add),
  .b_in      (b_in),
  .a_out     (a_out),
  .carry_out (carry_out),
  .sel_shl   (sel_shl),
  .sel_xor   (sel_xor),
  .sel_add   (sel_add),
  .load_en   (load_en)
);

// File: tb/mfreg_top_test.sv
module mfreg_top_test;

  localparam int W = 8;

  typedef struct packed {
    logic [2:0]   cmd;   // {add, xor, shl}
    logic [W-1:0] b;
    logic [W-1:0] ea;
    logic         ec;
  } vec_t;

  // walked in order from the reset state (A=0, carry=0)
  localparam vec_t VECS [0:16] = '{
    '{3'b100, 8'h5A, 8'h5A, 1'b0},  // R3
    '{3'b100, 8'hC3, 8'h1D, 1'b1},  // R3 wrap
    '{3'b000, 8'hFF, 8'h1D, 1'b1},  // R2 idle
    '{3'b010, 8'hF0, 8'hED, 1'b0},  // R4
    '{3'b001, 8'h33, 8'hDA, 1'b1},  // R5 R7
    '{3'b001, 8'h00, 8'hB4, 1'b1},  // R5
    '{3'b000, 8'h77, 8'hB4, 1'b1},  // R2
    '{3'b100, 8'h4C, 8'h00, 1'b1},  // R3 exact wrap
    '{3'b010, 8'hFF, 8'hFF, 1'b0},  // R4
    '{3'b100, 8'h01, 8'h00, 1'b1},  // R3
    '{3'b110, 8'h0F, 8'h0F, 1'b0},  // R6 add over xor
    '{3'b011, 8'h3C, 8'h33, 1'b0},  // R6 xor over shift
    '{3'b111, 8'hCD, 8'h00, 1'b1},  // R6 all three
    '{3'b001, 8'hA5, 8'h00, 1'b0},  // R5 R7
    '{3'b010, 8'h80, 8'h80, 1'b0},  // R4
    '{3'b001, 8'hFF, 8'h00, 1'b1},  // R5 top bit out
    '{3'b000, 8'h12, 8'h00, 1'b1}   // R2
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_shl, cmd_xor, cmd_add;
  logic [W-1:0] b_in;
  logic [W-1:0] a_out;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mfreg_top #(.W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .cmd_shl   (cmd_shl),
    .cmd_xor   (cmd_xor),
    .cmd_add   (cmd_add),
    .b_in      (b_in),
    .a_out     (a_out),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input logic [W-1:0] ea, input logic ec);
    checks++;
    if (a_out !== ea || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: a=%h c=%b expected a=%h c=%b", req, a_out, carry_out, ea, ec);
    end
  endtask

  // drive on falling edge, let one rising edge pass, sample 1 ns later
  task automatic step(input logic [2:0] cmd, input logic [W-1:0] b);
    @(negedge clk);
    {cmd_add, cmd_xor, cmd_shl} = cmd;
    b_in = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    {cmd_add, cmd_xor, cmd_shl} = 3'b000;
    b_in = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // vector table
    for (int i = 0; i < 17; i++) begin
      step(VECS[i].cmd, VECS[i].b);
      check($sformatf("R3/R4/R5/R6/R2 vector %0d", i), VECS[i].ea, VECS[i].ec);
    end

    // R8: the value changes exactly one edge after the command
    step(3'b100, 8'h21);
    check("R8 load after one edge", 8'h21, 1'b0);
    step(3'b000, 8'h00);
    check("R8 no extra load", 8'h21, 1'b0);

    // R7: shift with operand all ones and all zeros gives the same result
    step(3'b001, 8'hFF);
    check("R7 shift ignores operand", 8'h42, 1'b0);
    step(3'b001, 8'h00);
    check("R7 shift ignores operand", 8'h84, 1'b0);

    // R1: reset together with a command, reset wins
    @(negedge clk);
    rst = 1'b1;
    {cmd_add, cmd_xor, cmd_shl} = 3'b100;
    b_in = 8'h55;
    @(posedge clk);
    #1;
    check("R1 reset over add", 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    {cmd_add, cmd_xor, cmd_shl} = 3'b000;

    // random run against an integer reference model
    begin
      int ra = 0;
      int rc = 0;
      for (int n = 0; n < 3000; n++) begin
        logic [2:0]   cmd = 3'($urandom_range(0, 7));
        logic [W-1:0] bb  = W'($urandom);
        int t;
        if (n % 5 == 0) cmd = 3'b000;
        step(cmd, bb);
        if (cmd[2]) begin
          t = ra + int'(bb);
          ra = t % 256;
          rc = t / 256;
        end else if (cmd[1]) begin
          ra = ra ^ int'(bb);
          rc = 0;
        end else if (cmd[0]) begin
          rc = ra / 128;
          ra = (ra * 2) % 256;
        end
        check("R2/R3/R4/R5/R6 random", W'(ra), rc[0]);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: a=%h c=%b expected completion", a_out, carry_out);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule